// File: doc/BRIEF.md
# Power-On Serial Protocol Arbiter

This block decides which serial protocol owns a set of shared device pins once power comes up. Straight after reset it sits in a listening state in which the single-wire protocol owns the analog output pin, and it keeps that state for a programmable number of clock cycles. If the single-wire decoder reports a valid request during that window, the block locks into single-wire mode and stays there until that decoder reports an exit command, or until the next reset.

When the window runs out with no request, the block hands the serial pins to either I2C or SPI, chosen by a configuration input. It also gives the output pin back to its analog or PWM function, again chosen by a configuration input. A further configuration input can skip the window entirely, so the block moves to the configured protocol on the first clock after reset.

The block drives a one-hot mode indication and the enables of the pin multiplexers. The protocol engines and the output stage are outside this block.

Top module: `serial_mode_arbiter`

## Requirements
- R1: While reset is asserted, the block is in the listening state: mode_ow_o=1, mode_i2c_o=0, mode_spi_o=0, window_open_o=1, out_ow_en_o=1 and out_release_o=0.
- R2: With cfg_win_en_i=1 and no request, window_open_o stays 1 for exactly WIN_CYCLES rising edges after reset release, and the handover takes effect on edge WIN_CYCLES.
- R3: A high ow_req_i sampled at any edge while window_open_o=1 is a valid request. This includes the last edge of the window. From the next cycle on, mode_ow_o=1 and window_open_o=0.
- R4: In locked single-wire mode the block keeps mode_ow_o=1 until ow_exit_i is sampled high. After that it switches to the configured serial protocol on the next cycle.
- R5: At a handover, cfg_spi_i=1 selects SPI (mode_spi_o=1) and cfg_spi_i=0 selects I2C (mode_i2c_o=1). The value sampled at the handover edge decides.
- R6: Once in I2C or SPI mode, a request pulse on ow_req_i has no effect on the mode. Only a reset returns the block to single-wire mode.
- R7: With cfg_win_en_i=0, the first edge after reset release moves the block to the configured protocol without a window.
- R8: Outside single-wire mode, out_release_o=1 and exactly one of out_analog_en_o (cfg_pwm_i=0) or out_pwm_en_o (cfg_pwm_i=1) is set. In single-wire mode, out_release_o=0, out_ow_en_o=1 and both of those enables are 0.
- R9: io1_sdo_en_o and io2_ss_en_o are 1 only in SPI mode. sda_i2c_en_o is 1 only in I2C mode.
- R10: ow_exit_i has no effect outside locked single-wire mode. During the window, an exit pulse neither ends nor shortens it.
- R11: Exactly one of mode_ow_o, mode_i2c_o and mode_spi_o is 1 at every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_win_en_i | input | 1 | 1 opens the start-up listening window |
| cfg_spi_i | input | 1 | Protocol after handover: 1 SPI, 0 I2C |
| cfg_pwm_i | input | 1 | Output pin function after release: 1 PWM, 0 analog |
| ow_req_i | input | 1 | One-cycle valid-request pulse from the single-wire decoder |
| ow_exit_i | input | 1 | One-cycle exit-command pulse from the single-wire decoder |
| mode_ow_o | output | 1 | Single-wire protocol active (window or locked) |
| mode_i2c_o | output | 1 | I2C protocol active |
| mode_spi_o | output | 1 | SPI protocol active |
| window_open_o | output | 1 | Listening window still running |
| out_release_o | output | 1 | Output pin handed back to its analog/PWM function |
| out_analog_en_o | output | 1 | Output pin mux selects the analog driver |
| out_pwm_en_o | output | 1 | Output pin mux selects the PWM driver |
| out_ow_en_o | output | 1 | Output pin mux selects the single-wire transceiver |
| io1_sdo_en_o | output | 1 | IO1 mux selects SPI serial data out |
| io2_ss_en_o | output | 1 | IO2 mux selects SPI slave-select input |
| sda_i2c_en_o | output | 1 | Data pin mux selects I2C data |

## Verification
The assertions assume that the configuration inputs hold steady around each handover edge. They also assume that the request and exit inputs are single-cycle pulses that change only between clock edges. The stimulus drives every input on the falling edge, and it changes the configuration only while the block is in reset or in locked single-wire mode. Request pulses are placed on chosen edges relative to reset release: well inside the window, on its final edge, and one edge after it closes. This tests the window boundary from both sides. The window length is shortened through its parameter so that these cases take only a few dozen cycles.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    typedef enum logic [1:0] {
        SM_LISTEN  = 2'd0,
        SM_OW_LOCK = 2'd1,
        SM_I2C     = 2'd2,
        SM_SPI     = 2'd3
    } sel_mode_e;

    typedef struct packed {
        logic rel_en;
        logic analog_en;
        logic pwm_en;
        logic ow_en;
        logic io1_sdo_en;
        logic io2_ss_en;
        logic sda_en;
    } pin_route_t;

    function automatic sel_mode_e serial_pick(input logic spi);
        return spi ? SM_SPI : SM_I2C;
    endfunction

endpackage

// File: rtl/ssel_window_timer.sv
module ssel_window_timer #(
    parameter int unsigned WIN_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = (WIN_CYCLES < 2) ? 1 : $clog2(WIN_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LAST) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire_o = run_i && (tmr_q.cnt == LAST);

    // R2: the count never passes the final window cycle
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

endmodule

// File: rtl/ssel_mode_fsm.sv
module ssel_mode_fsm
    import ssel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win_en_i,
    input  logic      spi_i,
    input  logic      req_i,
    input  logic      exit_i,
    input  logic      expire_i,
    output sel_mode_e mode_o
);
    typedef struct packed {
        sel_mode_e mode;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.mode)
            SM_LISTEN: begin
                if (req_i)          fsm_d.mode = SM_OW_LOCK;
                else if (!win_en_i) fsm_d.mode = serial_pick(spi_i);
                else if (expire_i)  fsm_d.mode = serial_pick(spi_i);
            end
            SM_OW_LOCK: begin
                if (exit_i) fsm_d.mode = serial_pick(spi_i);
            end
            SM_I2C, SM_SPI: begin
                fsm_d.mode = fsm_q.mode;
            end
            default: fsm_d.mode = SM_LISTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{mode: SM_LISTEN};
        else        fsm_q <= fsm_d;
    end

    assign mode_o = fsm_q.mode;

    a_r3_req_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == SM_LISTEN && req_i) |=> (fsm_q.mode == SM_OW_LOCK));

    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == SM_OW_LOCK && !exit_i) |=> (fsm_q.mode == SM_OW_LOCK));

    a_r5_handover_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == SM_LISTEN && expire_i && !req_i)
            |=> (fsm_q.mode == serial_pick($past(spi_i))));

    a_r6_serial_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == SM_I2C || fsm_q.mode == SM_SPI) |=> $stable(fsm_q.mode));

    a_r7_skip_window: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == SM_LISTEN && !win_en_i && !req_i) |=> (fsm_q.mode != SM_LISTEN));

endmodule

// File: rtl/ssel_pin_route.sv
module ssel_pin_route
    import ssel_pkg::*;
(
    input  sel_mode_e  mode_i,
    input  logic       pwm_i,
    output pin_route_t route_o
);
    always_comb begin
        route_o = '0;
        unique case (mode_i)
            SM_LISTEN, SM_OW_LOCK: begin
                route_o.ow_en = 1'b1;
            end
            SM_I2C: begin
                route_o.rel_en    = 1'b1;
                route_o.analog_en = !pwm_i;
                route_o.pwm_en    = pwm_i;
                route_o.sda_en    = 1'b1;
            end
            SM_SPI: begin
                route_o.rel_en     = 1'b1;
                route_o.analog_en  = !pwm_i;
                route_o.pwm_en     = pwm_i;
                route_o.io1_sdo_en = 1'b1;
                route_o.io2_ss_en  = 1'b1;
            end
            default: route_o = '0;
        endcase
    end
endmodule

// File: rtl/serial_mode_arbiter.sv
module serial_mode_arbiter
    import ssel_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_win_en_i,
    input  logic cfg_spi_i,
    input  logic cfg_pwm_i,
    input  logic ow_req_i,
    input  logic ow_exit_i,
    output logic mode_ow_o,
    output logic mode_i2c_o,
    output logic mode_spi_o,
    output logic window_open_o,
    output logic out_release_o,
    output logic out_analog_en_o,
    output logic out_pwm_en_o,
    output logic out_ow_en_o,
    output logic io1_sdo_en_o,
    output logic io2_ss_en_o,
    output logic sda_i2c_en_o
);
    sel_mode_e  mode;
    logic       expire;
    pin_route_t route;

    ssel_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (mode == SM_LISTEN),
        .expire_o (expire)
    );

    ssel_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_en_i (cfg_win_en_i),
        .spi_i    (cfg_spi_i),
        .req_i    (ow_req_i),
        .exit_i   (ow_exit_i),
        .expire_i (expire),
        .mode_o   (mode)
    );

    ssel_pin_route u_route (
        .mode_i  (mode),
        .pwm_i   (cfg_pwm_i),
        .route_o (route)
    );

    assign mode_ow_o       = (mode == SM_LISTEN) || (mode == SM_OW_LOCK);
    assign mode_i2c_o      = (mode == SM_I2C);
    assign mode_spi_o      = (mode == SM_SPI);
    assign window_open_o   = (mode == SM_LISTEN);
    assign out_release_o   = route.rel_en;
    assign out_analog_en_o = route.analog_en;
    assign out_pwm_en_o    = route.pwm_en;
    assign out_ow_en_o     = route.ow_en;
    assign io1_sdo_en_o    = route.io1_sdo_en;
    assign io2_ss_en_o     = route.io2_ss_en;
    assign sda_i2c_en_o    = route.sda_en;

    a_r11_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_ow_o, mode_i2c_o, mode_spi_o}));

    a_r8_release_vs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        out_release_o != mode_ow_o);

    a_r8_one_function: assert property (@(posedge clk) disable iff (!rst_n)
        out_release_o |-> (out_analog_en_o ^ out_pwm_en_o));

    a_r9_spi_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (io1_sdo_en_o || io2_ss_en_o) |-> mode_spi_o);

    a_r9_i2c_pins: assert property (@(posedge clk) disable iff (!rst_n)
        sda_i2c_en_o |-> mode_i2c_o);

endmodule

// File: tb/sim_serial_mode_arbiter.sv
module sim_serial_mode_arbiter;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_win_en = 1'b1, cfg_spi = 1'b0, cfg_pwm = 1'b0;
    logic ow_req = 1'b0, ow_exit = 1'b0;
    logic m_ow, m_i2c, m_spi, win_open, rel, an_en, pwm_en, ow_en, sdo_en, ss_en, sda_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int st = 0;   // reference: 0 listen, 1 locked, 2 I2C, 3 SPI
    int wcnt = 0;

    always #5 clk = ~clk;

    serial_mode_arbiter #(.WIN_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_win_en_i(cfg_win_en), .cfg_spi_i(cfg_spi),
        .cfg_pwm_i(cfg_pwm), .ow_req_i(ow_req), .ow_exit_i(ow_exit),
        .mode_ow_o(m_ow), .mode_i2c_o(m_i2c), .mode_spi_o(m_spi),
        .window_open_o(win_open), .out_release_o(rel), .out_analog_en_o(an_en),
        .out_pwm_en_o(pwm_en), .out_ow_en_o(ow_en), .io1_sdo_en_o(sdo_en),
        .io2_ss_en_o(ss_en), .sda_i2c_en_o(sda_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            st = 0; wcnt = 0;
        end else begin
            case (st)
                0: begin
                    if (ow_req) st = 1;
                    else if (!cfg_win_en) st = cfg_spi ? 3 : 2;
                    else if (wcnt == W - 1) st = cfg_spi ? 3 : 2;
                    else wcnt++;
                end
                1: if (ow_exit) st = cfg_spi ? 3 : 2;
                default: ;
            endcase
        end
    end

    // compare every cycle, shortly after the edge
    always @(posedge clk) begin
        int e_mode, e_rel, e_pins;
        #2;
        e_mode = {st <= 1, st == 2, st == 3};
        e_rel  = {st >= 2, st >= 2 && !cfg_pwm, st >= 2 && cfg_pwm, st <= 1};
        e_pins = {st == 3, st == 3, st == 2};
        chk({m_ow, m_i2c, m_spi} == 3'(e_mode), "R5/R11 mode", {m_ow, m_i2c, m_spi}, e_mode);
        chk(win_open == (st == 0), "R2 window", win_open, st == 0);
        chk({rel, an_en, pwm_en, ow_en} == 4'(e_rel), "R8 output pin", {rel, an_en, pwm_en, ow_en}, e_rel);
        chk({sdo_en, ss_en, sda_en} == 3'(e_pins), "R9 serial pins", {sdo_en, ss_en, sda_en}, e_pins);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic do_reset(input logic wen, input logic spi, input logic pwm);
        @(negedge clk);
        rst_n = 1'b0; cfg_win_en = wen; cfg_spi = spi; cfg_pwm = pwm;
        ow_req = 1'b0; ow_exit = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(m_ow && !m_i2c && !m_spi && win_open && ow_en && !rel, "R1 reset state",
            {m_ow, m_i2c, m_spi, win_open, ow_en, rel}, 6'b100110);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        ow_req = 1'b1; @(negedge clk); ow_req = 1'b0;
    endtask

    task automatic pulse_exit();
        ow_exit = 1'b1; @(negedge clk); ow_exit = 1'b0;
    endtask

    initial begin
        // window expires with no request: I2C, analog
        do_reset(1'b1, 1'b0, 1'b0);
        idle(W - 1);
        chk(win_open, "R2 open on edge W-1", win_open, 1);
        idle(1);
        chk(m_i2c && !win_open && an_en, "R2 handover on edge W", {m_i2c, win_open, an_en}, 3'b101);
        idle(4);

        // SPI with PWM, then late request and exit are ignored
        do_reset(1'b1, 1'b1, 1'b1);
        idle(W + 2);
        chk(m_spi && pwm_en && ss_en && sdo_en, "R5 SPI handover", {m_spi, pwm_en, ss_en, sdo_en}, 4'hf);
        pulse_req(); idle(2);
        chk(m_spi && !m_ow, "R6 request after window ignored", {m_spi, m_ow}, 2'b10);
        pulse_exit(); idle(2);
        chk(m_spi, "R10 exit ignored in SPI", m_spi, 1);

        // request in window locks; exit picks current config
        do_reset(1'b1, 1'b1, 1'b0);
        idle(5); pulse_req();
        chk(m_ow && !win_open, "R3 lock after request", {m_ow, win_open}, 2'b10);
        idle(3 * W);
        chk(m_ow && ow_en && !rel, "R4 lock held past window", {m_ow, ow_en, rel}, 3'b110);
        cfg_spi = 1'b0;
        pulse_exit();
        chk(m_i2c && rel && an_en, "R4 exit to I2C", {m_i2c, rel, an_en}, 3'b111);
        idle(3);

        // request on the final window edge
        do_reset(1'b1, 1'b0, 1'b0);
        idle(W - 1); pulse_req();
        chk(m_ow && !win_open, "R3 last-edge request locks", {m_ow, win_open}, 2'b10);
        idle(3);

        // request one edge after window close
        do_reset(1'b1, 1'b0, 1'b1);
        idle(W); pulse_req();
        chk(m_i2c && pwm_en, "R6 request past window ignored", {m_i2c, pwm_en}, 2'b11);
        idle(2);

        // exit during window has no effect
        do_reset(1'b1, 1'b1, 1'b0);
        idle(3); pulse_exit();
        chk(win_open && m_ow, "R10 exit in window ignored", {win_open, m_ow}, 2'b11);
        idle(W - 6);
        chk(win_open, "R10 window not shortened", win_open, 1);
        idle(3);
        chk(m_spi, "R10 handover after full window", m_spi, 1);

        // window disabled
        do_reset(1'b0, 1'b1, 1'b1);
        idle(1);
        chk(m_spi && !win_open && pwm_en, "R7 direct to SPI", {m_spi, win_open, pwm_en}, 3'b101);
        idle(2);
        do_reset(1'b0, 1'b0, 1'b0);
        idle(1);
        chk(m_i2c && sda_en && !ss_en, "R7 direct to I2C", {m_i2c, sda_en, ss_en}, 3'b110);
        idle(3);

        summary();
        $finish;
    end
endmodule